// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block decides what each of four LEDs next to an Ethernet PHY shows. It watches the PHY's link speed and its status flags: power-down, energy-efficient mode, auto-negotiation, analog self-test, cable diagnostics and test mode. It also watches single-cycle strobes for transmit, receive and collision activity. Each LED has four independent sources. A steady-on condition, a fast-blink condition and a slow-blink condition each pick one speed or state from a shared 4-bit code. An event mask picks which activity strobes flash the LED.

A small register port holds the configuration: one global pair of registers and one pair of registers per LED. The global pair sets the two blink rates, which all LEDs share, and a global condition that forces every LED onto the slow blink waveform. Both blink waveforms come from a divider of the block clock, whose frequency is a parameter. This lets a bench scale the rates down to a few hundred cycles.

Top module: `led_behav_ctrl`

## Requirements
- R1: After reset the registers read as follows. Global high is 0x00C5 and global low is 0x0067. The per-LED high registers for LED0..LED3 read 0x0070, 0x0020, 0x0040, 0x0040. The per-LED low registers read 0x0003, 0x0000, 0x0000, 0x0020. With all status inputs low, all LEDs are off.
- R2: Register index k is at address 0x1E0+k. Index 0 is global high, 1 is global low, 2+2n is the high register of LED n and 3+2n is its low register. Global high holds fast rate [7:6], slow rate [5:4] and inverse-scan select [2:0]. Global low holds scan select [6:4] and complex-blink select [2:0]. LED high holds steady-on [7:4] and fast-blink [3:0]. LED low holds slow-blink [7:4] and event mask [2:0]. Bits [15:8], global high bit 3, global low bits 7 and 3, and LED low bit 3 read zero. Writes to those bits are ignored, and any address outside the ten registers reads zero.
- R3: The 4-bit condition code means the following. 0 is never. 1 is link at 10, 2 is link at 100 and 3 is link at 10 or 100. 4 is link at 1000, 5 is 10 or 1000, 6 is 100 or 1000 and 7 is any link. 8 is power-down, 9 is energy-efficient mode, 0xA is auto-negotiation, 0xB is self-test and 0xC is cable diagnostics. 0xD..0xF mean never. The link_speed input encodes 0 as down, 1 as 10, 2 as 100 and 3 as 1000. An LED whose only true condition is steady-on is lit.
- R4: Blink rate codes 0..3 give 2, 4, 8 and 16 Hz, each with a 50% duty cycle. That is a full period of CLK_HZ/(2<<code) cycles.
- R5: Per LED, an active fast-blink condition takes precedence over slow-blink, slow-blink over steady-on, and steady-on over off.
- R6: An activity strobe enabled by the LED's event mask (bit 0 transmit, bit 1 receive, bit 2 collision) inverts the LED from the following cycle for STRETCH_CYC cycles. A new enabled strobe restarts that window.
- R7: Strobes whose mask bit is clear, and the reserved mask bit 3, have no effect on the LED.
- R8: While the complex-blink condition holds, every LED follows the slow blink waveform. The condition's 3-bit codes are 0 never, 1 link up, 2 power-down, 3 energy-efficient, 4 auto-negotiation, 5 self-test, 6 cable diagnostics and 7 test mode.
- R9: A change of a blink rate restarts that waveform low with its counter at zero. The first rising edge then comes exactly one new half period after the restart cycle.
- R10: A register write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address, shared by read and write |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| link_speed | input | 2 | 0 down, 1 10M, 2 100M, 3 1000M |
| pwr_down | input | 1 | PHY powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode running |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| col_evt | input | 1 | Collision strobe |
| led | output | NUM_LEDS | LED drive, 1 is lit |

## Verification
The bench sweeps all sixteen steady-on codes against every link speed and every single status flag. A decoder with a swapped speed bit, or one that lets 0xD..0xF light the LED, shows up as a wrong level. Every fast and slow rate is timed from one rising edge to the next, which catches a divider off by a factor of two or a shared rate field read from the wrong bits. A rate change is probed cycle by cycle: a design that does not restart its counter rises early or late. The pulse tests time the stretch window exactly, both over a dark LED and over a lit one, and also check a retrigger in mid-window and strobes that should be masked. A design that only forces the LED on, extends the window by a cycle, or ignores the mask fails these. The complex-blink checks confirm that all four LEDs share one waveform and return to their own settings once the condition drops.

// File: rtl/led_behav_pkg.sv
package led_behav_pkg;

    typedef enum logic [1:0] {
        SPD_DOWN = 2'd0,
        SPD_10   = 2'd1,
        SPD_100  = 2'd2,
        SPD_1000 = 2'd3
    } speed_e;

    typedef struct packed {
        speed_e speed;
        logic   pdown;
        logic   eee;
        logic   aneg;
        logic   selftest;
        logic   cdiag;
        logic   testmode;
    } phy_state_t;

    typedef struct packed {
        logic [1:0] fast_rate;
        logic [1:0] slow_rate;
        logic [2:0] inv_scan;
        logic [2:0] scan_sel;
        logic [2:0] cblink_sel;
    } glb_cfg_t;

    typedef struct packed {
        logic [3:0] on_sel;
        logic [3:0] fast_sel;
        logic [3:0] slow_sel;
        logic [2:0] evt_mask;
    } led_cfg_t;

    localparam int EVT_TX  = 0;
    localparam int EVT_RX  = 1;
    localparam int EVT_COL = 2;

    // 4-bit per-LED condition decode
    function automatic logic cond_match(input logic [3:0] code, input phy_state_t s);
        logic hit;
        hit = 1'b0;
        if (code != 4'd0 && code <= 4'd7) begin
            hit = (code[0] && s.speed == SPD_10)  ||
                  (code[1] && s.speed == SPD_100) ||
                  (code[2] && s.speed == SPD_1000);
        end else begin
            case (code)
                4'h8:    hit = s.pdown;
                4'h9:    hit = s.eee;
                4'hA:    hit = s.aneg;
                4'hB:    hit = s.selftest;
                4'hC:    hit = s.cdiag;
                default: hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

    // 3-bit global condition decode
    function automatic logic gcond_match(input logic [2:0] code, input phy_state_t s);
        case (code)
            3'd1:    return s.speed != SPD_DOWN;
            3'd2:    return s.pdown;
            3'd3:    return s.eee;
            3'd4:    return s.aneg;
            3'd5:    return s.selftest;
            3'd6:    return s.cdiag;
            3'd7:    return s.testmode;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] led_rst_hi(input int idx);
        case (idx)
            0:       return 8'h70;
            1:       return 8'h20;
            2:       return 8'h40;
            3:       return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] led_rst_lo(input int idx);
        case (idx)
            0:       return 8'h03;
            3:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    function automatic led_cfg_t led_unpack(input logic [7:0] hi, input logic [7:0] lo);
        led_cfg_t c;
        c.on_sel   = hi[7:4];
        c.fast_sel = hi[3:0];
        c.slow_sel = lo[7:4];
        c.evt_mask = lo[2:0];
        return c;
    endfunction

    function automatic logic [15:0] glb_hi_word(input glb_cfg_t g);
        return {8'h00, g.fast_rate, g.slow_rate, 1'b0, g.inv_scan};
    endfunction

    function automatic logic [15:0] glb_lo_word(input glb_cfg_t g);
        return {8'h00, 1'b0, g.scan_sel, 1'b0, g.cblink_sel};
    endfunction

    function automatic logic [15:0] led_hi_word(input led_cfg_t c);
        return {8'h00, c.on_sel, c.fast_sel};
    endfunction

    function automatic logic [15:0] led_lo_word(input led_cfg_t c);
        return {8'h00, c.slow_sel, 1'b0, c.evt_mask};
    endfunction

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_behav_pkg::*;
#(
    parameter int                NUM_LEDS  = 4,
    parameter int                ADDR_W    = 9,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 9'h1E0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [15:0]              wdata,
    input  logic                     we,
    output logic [15:0]              rdata,
    output glb_cfg_t                 glb,
    output led_cfg_t [NUM_LEDS-1:0]  leds
);
    localparam int NUM_REGS = 2 + 2 * NUM_LEDS;

    logic [ADDR_W-1:0] idx;
    logic [7:0]        wbyte;
    logic [7:0]        wdata_hi_unused;

    assign idx             = addr - BASE_ADDR;
    assign wbyte           = wdata[7:0];
    assign wdata_hi_unused = wdata[15:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            glb.fast_rate  <= 2'd3;
            glb.slow_rate  <= 2'd0;
            glb.inv_scan   <= 3'd5;
            glb.scan_sel   <= 3'd6;
            glb.cblink_sel <= 3'd7;
            for (int i = 0; i < NUM_LEDS; i++) begin
                leds[i] <= led_unpack(led_rst_hi(i), led_rst_lo(i));
            end
        end else if (we) begin
            if (idx == ADDR_W'(0)) begin
                glb.fast_rate <= wbyte[7:6];
                glb.slow_rate <= wbyte[5:4];
                glb.inv_scan  <= wbyte[2:0];
            end
            if (idx == ADDR_W'(1)) begin
                glb.scan_sel   <= wbyte[6:4];
                glb.cblink_sel <= wbyte[2:0];
            end
            for (int i = 0; i < NUM_LEDS; i++) begin
                if (idx == ADDR_W'(2 + 2 * i)) begin
                    leds[i].on_sel   <= wbyte[7:4];
                    leds[i].fast_sel <= wbyte[3:0];
                end
                if (idx == ADDR_W'(3 + 2 * i)) begin
                    leds[i].slow_sel <= wbyte[7:4];
                    leds[i].evt_mask <= wbyte[2:0];
                end
            end
        end
    end

    always_comb begin
        rdata = 16'h0000;
        if (idx == ADDR_W'(0)) rdata = glb_hi_word(glb);
        if (idx == ADDR_W'(1)) rdata = glb_lo_word(glb);
        for (int i = 0; i < NUM_LEDS; i++) begin
            if (idx == ADDR_W'(2 + 2 * i)) rdata = led_hi_word(leds[i]);
            if (idx == ADDR_W'(3 + 2 * i)) rdata = led_lo_word(leds[i]);
        end
        if (idx >= ADDR_W'(NUM_REGS)) rdata = 16'h0000;
    end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate,
    output logic       phase
);
    // half period of the slowest (2 Hz) wave, in cycles
    localparam int HALF_MAX = CLK_HZ / 4;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic [1:0]       rate_q;

    assign half = CNT_W'(HALF_MAX >> rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            phase  <= 1'b0;
            rate_q <= rate;
        end else if (rate != rate_q) begin
            cnt    <= '0;
            phase  <= 1'b0;
            rate_q <= rate;
        end else if (cnt == half - CNT_W'(1)) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/led_lane.sv
module led_lane
    import led_behav_pkg::*;
#(
    parameter int STRETCH_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  led_cfg_t   cfg,
    input  phy_state_t st,
    input  logic       fast_ph,
    input  logic       slow_ph,
    input  logic       cb_hit,
    input  logic       tx_act,
    input  logic       rx_act,
    input  logic       col_evt,
    output logic       led,
    output logic       stretching
);
    localparam int SW = $clog2(STRETCH_CYC + 1);

    logic [SW-1:0] scnt;
    logic          evt;
    logic          base;

    assign evt = (tx_act  && cfg.evt_mask[EVT_TX]) ||
                 (rx_act  && cfg.evt_mask[EVT_RX]) ||
                 (col_evt && cfg.evt_mask[EVT_COL]);

    always_ff @(posedge clk) begin
        if (rst)               scnt <= '0;
        else if (evt)          scnt <= SW'(STRETCH_CYC);
        else if (scnt != '0)   scnt <= scnt - SW'(1);
    end

    assign stretching = (scnt != '0);

    always_comb begin
        if (cond_match(cfg.fast_sel, st))      base = fast_ph;
        else if (cond_match(cfg.slow_sel, st)) base = slow_ph;
        else if (cond_match(cfg.on_sel, st))   base = 1'b1;
        else                                   base = 1'b0;
    end

    assign led = cb_hit ? slow_ph : (base ^ stretching);

endmodule

// File: rtl/led_behav_ctrl.sv
module led_behav_ctrl
    import led_behav_pkg::*;
#(
    parameter int                CLK_HZ      = 125_000_000,
    parameter int                NUM_LEDS    = 4,
    parameter int                STRETCH_CYC = 5_000_000,
    parameter int                ADDR_W      = 9,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 9'h1E0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [15:0]         reg_wdata,
    input  logic                reg_we,
    output logic [15:0]         reg_rdata,
    input  logic [1:0]          link_speed,
    input  logic                pwr_down,
    input  logic                eee_mode,
    input  logic                aneg_busy,
    input  logic                selftest_busy,
    input  logic                cdiag_busy,
    input  logic                test_mode,
    input  logic                tx_act,
    input  logic                rx_act,
    input  logic                col_evt,
    output logic [NUM_LEDS-1:0] led
);
    glb_cfg_t                glb;
    led_cfg_t [NUM_LEDS-1:0] leds;
    phy_state_t              st;
    logic                    fast_ph;
    logic                    slow_ph;
    logic                    cb_hit;
    logic [NUM_LEDS-1:0]     stretch_on;

    assign st.speed    = speed_e'(link_speed);
    assign st.pdown    = pwr_down;
    assign st.eee      = eee_mode;
    assign st.aneg     = aneg_busy;
    assign st.selftest = selftest_busy;
    assign st.cdiag    = cdiag_busy;
    assign st.testmode = test_mode;

    assign cb_hit = gcond_match(glb.cblink_sel, st);

    led_cfg_regs #(
        .NUM_LEDS (NUM_LEDS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .we   (reg_we),
        .rdata(reg_rdata),
        .glb  (glb),
        .leds (leds)
    );

    led_blink_gen #(.CLK_HZ(CLK_HZ)) u_fast (
        .clk(clk), .rst(rst), .rate(glb.fast_rate), .phase(fast_ph)
    );

    led_blink_gen #(.CLK_HZ(CLK_HZ)) u_slow (
        .clk(clk), .rst(rst), .rate(glb.slow_rate), .phase(slow_ph)
    );

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lane
        led_lane #(.STRETCH_CYC(STRETCH_CYC)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .cfg       (leds[g]),
            .st        (st),
            .fast_ph   (fast_ph),
            .slow_ph   (slow_ph),
            .cb_hit    (cb_hit),
            .tx_act    (tx_act),
            .rx_act    (rx_act),
            .col_evt   (col_evt),
            .led       (led[g]),
            .stretching(stretch_on[g])
        );
    end

endmodule

// File: rtl/led_behav_chk.sv
module led_behav_chk
    import led_behav_pkg::*;
#(
    parameter int NUM_LEDS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [15:0]             reg_rdata,
    input logic [NUM_LEDS-1:0]     led,
    input logic                    cb_hit,
    input glb_cfg_t                glb,
    input led_cfg_t [NUM_LEDS-1:0] leds,
    input logic                    fast_ph,
    input logic                    slow_ph,
    input logic                    tx_act,
    input logic                    rx_act,
    input logic                    col_evt,
    input logic [NUM_LEDS-1:0]     stretch_on
);
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15:8] == 8'h00);                                              // R2

    AST_COMPLEX_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        cb_hit |-> ($countones(led) == 0 || $countones(led) == NUM_LEDS));      // R8

    AST_SLOW_RESTART: assert property (@(posedge clk) disable iff (rst)
        (glb.slow_rate != $past(glb.slow_rate)) |=> !slow_ph);                  // R9

    AST_FAST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (glb.fast_rate != $past(glb.fast_rate)) |=> !fast_ph);                  // R9

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_evt
        AST_EVENT_STRETCH: assert property (@(posedge clk) disable iff (rst)
            ((tx_act && leds[g].evt_mask[0]) || (rx_act && leds[g].evt_mask[1]) ||
             (col_evt && leds[g].evt_mask[2])) |=> stretch_on[g]);              // R6
    end

endmodule

bind led_behav_ctrl led_behav_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .led       (led),
    .cb_hit    (cb_hit),
    .glb       (glb),
    .leds      (leds),
    .fast_ph   (fast_ph),
    .slow_ph   (slow_ph),
    .tx_act    (tx_act),
    .rx_act    (rx_act),
    .col_evt   (col_evt),
    .stretch_on(stretch_on)
);

// File: tb/led_behav_ctrl_tb.sv
`timescale 1ns/1ps
module led_behav_ctrl_tb;
    localparam int CLK_HZ  = 640;
    localparam int NL      = 4;
    localparam int STR     = 5;
    localparam int AW      = 9;
    localparam int HALF0   = CLK_HZ / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [15:0]   reg_rdata;
    logic [1:0]    link_speed = 2'd0;
    logic          pwr_down = 0, eee_mode = 0, aneg_busy = 0, selftest_busy = 0;
    logic          cdiag_busy = 0, test_mode = 0;
    logic          tx_act = 0, rx_act = 0, col_evt = 0;
    logic [NL-1:0] led;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    led_behav_ctrl #(
        .CLK_HZ(CLK_HZ), .NUM_LEDS(NL), .STRETCH_CYC(STR), .ADDR_W(AW), .BASE_ADDR(9'h1E0)
    ) u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .link_speed(link_speed), .pwr_down(pwr_down),
        .eee_mode(eee_mode), .aneg_busy(aneg_busy), .selftest_busy(selftest_busy),
        .cdiag_busy(cdiag_busy), .test_mode(test_mode), .tx_act(tx_act), .rx_act(rx_act),
        .col_evt(col_evt), .led(led)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [15:0] d);
        @(negedge clk);
        reg_addr = AW'(9'h1E0 + idx); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int addr, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = AW'(addr);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        tx_act = (which == 0); rx_act = (which == 1); col_evt = (which == 2);
        @(negedge clk);
        tx_act = 0; rx_act = 0; col_evt = 0;
    endtask

    task automatic measure(input int lane, output int per);
        int n;
        n = 0; per = 0;
        while (led[lane] !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
        while (led[lane] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        while (led[lane] !== 1'b0 && n < 4000) begin @(negedge clk); n++; per++; end
        while (led[lane] !== 1'b1 && n < 4000) begin @(negedge clk); n++; per++; end
    endtask

    function automatic logic exp_cond(input int code, input int spd, input int sti);
        if (code >= 1 && code <= 7)
            return ((code & 1) != 0 && spd == 1) || ((code & 2) != 0 && spd == 2) ||
                   ((code & 4) != 0 && spd == 3);
        if (code >= 8 && code <= 12) return sti == code - 7;
        return 1'b0;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int per;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_chk("R1 glb hi", 9'h1E0, 16'h00C5);
        rd_chk("R1 glb lo", 9'h1E1, 16'h0067);
        rd_chk("R1 led0 hi", 9'h1E2, 16'h0070);
        rd_chk("R1 led0 lo", 9'h1E3, 16'h0003);
        rd_chk("R1 led1 hi", 9'h1E4, 16'h0020);
        rd_chk("R1 led1 lo", 9'h1E5, 16'h0000);
        rd_chk("R1 led2 hi", 9'h1E6, 16'h0040);
        rd_chk("R1 led2 lo", 9'h1E7, 16'h0000);
        rd_chk("R1 led3 hi", 9'h1E8, 16'h0040);
        rd_chk("R1 led3 lo", 9'h1E9, 16'h0020);
        check("R1 leds off", 32'(led), 32'h0);
        link_speed = 2'd3; #1;
        check("R3 default map at 1000", 32'(led), 32'hD);
        link_speed = 2'd0;

        // R2 masking and map
        for (int i = 0; i < 10; i++) wr(i, 16'hFFFF);
        rd_chk("R2 glb hi mask", 9'h1E0, 16'h00F7);
        rd_chk("R2 glb lo mask", 9'h1E1, 16'h0077);
        for (int i = 0; i < NL; i++) begin
            rd_chk("R2 led hi", 9'h1E2 + 2 * i, 16'h00FF);
            rd_chk("R2 led lo mask", 9'h1E3 + 2 * i, 16'h00F7);
        end
        rd_chk("R2 out of range high", 9'h1EA, 16'h0000);
        rd_chk("R2 out of range low", 9'h000, 16'h0000);
        wr(1, 16'h0000);
        wr(3, 16'h0000);
        wr(5, 16'h0000);
        wr(7, 16'h0000);
        wr(9, 16'h0000);

        // R10 write takes effect at sampling edge
        link_speed = 2'd1;
        @(negedge clk);
        reg_addr = 9'h1E2; reg_wdata = 16'h0070; reg_we = 1'b1; #1;
        check("R10 before edge", 32'(led[0]), 32'h0);
        @(negedge clk);
        reg_we = 1'b0;
        check("R10 after edge", 32'(led[0]), 32'h1);

        // R3 exhaustive steady-on sweep on LED0
        for (int code = 0; code < 16; code++) begin
            wr(2, 16'(code << 4));
            for (int spd = 0; spd < 4; spd++) begin
                for (int sti = 0; sti < 6; sti++) begin
                    @(negedge clk);
                    link_speed = 2'(spd);
                    pwr_down = (sti == 1); eee_mode = (sti == 2); aneg_busy = (sti == 3);
                    selftest_busy = (sti == 4); cdiag_busy = (sti == 5);
                    #1;
                    check($sformatf("R3 code %0d spd %0d st %0d", code, spd, sti),
                          32'(led[0]), 32'(exp_cond(code, spd, sti)));
                end
            end
        end
        pwr_down = 0; eee_mode = 0; aneg_busy = 0; selftest_busy = 0; cdiag_busy = 0;
        wr(2, 16'h0000);

        // R4 rates
        link_speed = 2'd2;
        wr(4, 16'h0007);
        for (int r = 0; r < 4; r++) begin
            wr(0, 16'(r << 6));
            measure(1, per);
            check($sformatf("R4 fast rate %0d period", r), 32'(per), 32'(CLK_HZ / (2 << r)));
        end
        wr(4, 16'h0000);
        wr(5, 16'h0070);
        for (int r = 0; r < 4; r++) begin
            wr(0, 16'((3 << 6) | (r << 4)));
            measure(1, per);
            check($sformatf("R4 slow rate %0d period", r), 32'(per), 32'(CLK_HZ / (2 << r)));
        end

        // R5 priority
        wr(0, 16'h00C0);
        wr(4, 16'h0077);
        measure(1, per);
        check("R5 fast over slow and steady", 32'(per), 32'(CLK_HZ / 16));
        wr(4, 16'h0070);
        measure(1, per);
        check("R5 slow over steady", 32'(per), 32'(CLK_HZ / 2));
        wr(5, 16'h0000);
        bad = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); if (led[1] !== 1'b1) bad++; end
        check("R5 steady lit", 32'(bad), 32'h0);
        wr(4, 16'h0000);

        // R9 restart on slow rate change (0 -> 2, half = 40)
        wr(7, 16'h0070);
        repeat (7) @(negedge clk);
        wr(0, 16'h00E0);
        bad = 0;
        for (int k = 1; k <= (HALF0 >> 2) + 1; k++) begin
            @(negedge clk);
            if (k <= (HALF0 >> 2) && led[2] !== 1'b0) bad++;
            if (k == (HALF0 >> 2) + 1 && led[2] !== 1'b1) bad++;
        end
        check("R9 slow restart timing", 32'(bad), 32'h0);
        wr(7, 16'h0000);

        // R6 pulse over dark LED3
        wr(8, 16'h0000);
        wr(9, 16'h0001);
        strobe(0);
        bad = 0;
        for (int k = 0; k < STR; k++) begin
            if (led[3] !== 1'b1) bad++;
            @(negedge clk);
        end
        if (led[3] !== 1'b0) bad++;
        check("R6 tx stretch window", 32'(bad), 32'h0);
        // retrigger
        strobe(0);
        repeat (2) @(negedge clk);
        strobe(0);
        bad = 0;
        for (int k = 0; k < STR; k++) begin
            if (led[3] !== 1'b1) bad++;
            @(negedge clk);
        end
        if (led[3] !== 1'b0) bad++;
        check("R6 retrigger window", 32'(bad), 32'h0);
        // pulse over lit LED blanks it
        wr(8, 16'h0070);
        wr(9, 16'h0004);
        check("R6 lit before pulse", 32'(led[3]), 32'h1);
        strobe(2);
        bad = 0;
        for (int k = 0; k < STR; k++) begin
            if (led[3] !== 1'b0) bad++;
            @(negedge clk);
        end
        if (led[3] !== 1'b1) bad++;
        check("R6 collision blanks lit LED", 32'(bad), 32'h0);

        // R7 masked strobes and reserved bit
        wr(8, 16'h0000);
        wr(9, 16'h0001);
        strobe(1);
        strobe(2);
        bad = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (led[3] !== 1'b0) bad++; end
        check("R7 masked rx and col", 32'(bad), 32'h0);
        wr(9, 16'h0008);
        strobe(0); strobe(1); strobe(2);
        bad = 0;
        for (int k = 0; k < 8; k++) begin @(negedge clk); if (led[3] !== 1'b0) bad++; end
        check("R7 reserved mask bit", 32'(bad), 32'h0);
        wr(9, 16'h0000);

        // R8 complex blink override
        wr(2, 16'h0070);
        wr(4, 16'h0007);
        wr(0, 16'h00E0);
        link_speed = 2'd3;
        wr(1, 16'h0001);
        measure(0, per);
        check("R8 link-up override period", 32'(per), 32'(CLK_HZ / 8));
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (led !== {NL{led[0]}}) bad++;
        end
        check("R8 all LEDs share waveform", 32'(bad), 32'h0);
        link_speed = 2'd0;
        test_mode = 1'b1;
        wr(1, 16'h0007);
        measure(2, per);
        check("R8 test-mode override period", 32'(per), 32'(CLK_HZ / 8));
        test_mode = 1'b0;
        #1;
        check("R8 release returns own settings", 32'(led), 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule